// File: doc/BRIEF.md
# Palette Lookup Table with Indexed Register Port

This block holds a 256-entry colour table. Each entry carries a red, a green and a blue component of 6 bits. Software reaches the table through a byte-wide register port with four registers: a write pointer, a read pointer, one data register shared by both directions, and a pixel mask. The data register has no address of its own. Each access to it steps a modulo-3 component counter through red, green and blue. After blue, the entry pointer for that direction advances by one. Loading a whole palette is therefore one pointer write followed by a run of data writes.

The write and read directions have separate pointers and separate component counters. A readback can run in the middle of a load without disturbing it. On the video side, a pixel port ANDs an 8-bit pixel value with the mask register. It looks up the masked entry and presents the three components as one 18-bit word on the following clock.

Register select codes: 0 is the write pointer, 1 is the read pointer, 2 is data, 3 is the pixel mask. A register access happens on a clock edge where `reg_en` is high. `reg_we` chooses between write and read. Read data appears on `reg_rdata` after that edge and holds until the next read.

Top module: `pal_lut_port`

## Requirements
- R1: After reset both pointers are 0, both component counters point at red, the mask is 0xFF, and `reg_rdata` and `pix_rgb` are 0.
- R2: A write to select 0 loads the write pointer and returns the write counter to red. A read of select 0 returns the current write pointer.
- R3: Successive writes to select 2 store red, then green, then blue of the entry at the write pointer. The write pointer advances by one after the blue write and stays put after the red and green writes.
- R4: The write pointer wraps from 255 to 0. After 768 data writes that start at entry 0, a read of select 0 returns 0.
- R5: A write to select 1 loads the read pointer and returns the read counter to red. Successive reads of select 2 return red, green and blue of that entry, then move to the next entry, wrapping from 255 to 0. A read of select 1 returns the read pointer. Every register read shows on `reg_rdata` one clock after the access edge.
- R6: Components occupy data bits 5 to 0. Bits 7 and 6 of a data write are discarded. A data read returns 0 in bits 7 and 6.
- R7: A write to select 3 sets the pixel mask, and a read of select 3 returns it. The pixel value is ANDed with the mask before lookup, so a mask of 0xFF passes the pixel value unchanged.
- R8: The read and write counters are independent. Loading either pointer leaves the other direction's pointer and counter unchanged.
- R9: `pix_rgb` shows the entry selected by the pixel value and mask sampled at a clock edge, one edge later. Red is in bits 17 to 12, green in bits 11 to 6 and blue in bits 5 to 0.
- R10: When a data write and a pixel lookup address the same entry at the same edge, the lookup returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 2 | Register select: 0 write pointer, 1 read pointer, 2 data, 3 pixel mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue}, registered |

## Verification
The hardest situations to reach from the ports are those where the two component counters are out of step. One case is a read-pointer reload in the middle of an entry's write sequence; the other is a write-pointer reload partway through. The stimulus interleaves single data writes with pointer reloads and data reads on the same entry. A stale or shared counter then sends a component to the wrong slot, and the following reads expose it. A same-edge collision is forced by holding the pixel value on one entry while all three of that entry's components are rewritten. The bench model compares every clock against a behavioural table built from queue-free integer arrays.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;

   // register select codes on the byte port
   typedef enum logic [1:0] {
      SEL_WPTR = 2'd0,
      SEL_RPTR = 2'd1,
      SEL_DATA = 2'd2,
      SEL_MASK = 2'd3
   } pal_sel_e;

   // number of colour components per entry (red, green, blue)
   localparam int unsigned PAL_NCOMP = 3;

   // one-cycle strobes produced by the register decoder
   typedef struct packed {
      logic wptr_load;
      logic rptr_load;
      logic data_wr;
      logic data_rd;
      logic mask_wr;
      logic any_rd;
   } pal_strobe_t;

endpackage

// File: rtl/pal_reg_decode.sv
module pal_reg_decode
   import pal_lut_pkg::*;
(
   input  logic        reg_en,
   input  logic        reg_we,
   input  logic [1:0]  reg_sel,
   output pal_strobe_t strobe
);

   logic     wr_acc;
   logic     rd_acc;
   pal_sel_e sel;

   assign sel    = pal_sel_e'(reg_sel);
   assign wr_acc = reg_en &  reg_we;
   assign rd_acc = reg_en & ~reg_we;

   always_comb begin
      strobe           = '0;
      strobe.any_rd    = rd_acc;
      unique case (sel)
         SEL_WPTR: strobe.wptr_load = wr_acc;
         SEL_RPTR: strobe.rptr_load = wr_acc;
         SEL_DATA: begin
            strobe.data_wr = wr_acc;
            strobe.data_rd = rd_acc;
         end
         SEL_MASK: strobe.mask_wr = wr_acc;
         default:  strobe = '0;
      endcase
   end

endmodule

// File: rtl/pal_idx_seq.sv
module pal_idx_seq #(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned NCOMP = 3,
   localparam int unsigned CW   = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic [CW-1:0]    comp
);

   localparam logic [CW-1:0] LAST_COMP = CW'(NCOMP - 1);

   if (NCOMP < 1) begin : g_bad_ncomp
      $error("pal_idx_seq: NCOMP must be at least 1");
   end

   logic last;
   assign last = (comp == LAST_COMP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= '0;
      end else if (load) begin
         idx  <= load_val;
         comp <= '0;
      end else if (step) begin
         if (last) begin
            comp <= '0;
            idx  <= idx + 1'b1;
         end else begin
            comp <= comp + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pal_comp_bank.sv
module pal_comp_bank #(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 6,
   parameter bit          PIX_REG = 1'b1,
   localparam int unsigned DEPTH  = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [COMP_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [COMP_W-1:0] rdata,
   input  logic [IDX_W-1:0]  pix_addr,
   output logic [COMP_W-1:0] pix_data
);

   logic [COMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   if (PIX_REG) begin : g_pix_reg
      logic [COMP_W-1:0] pix_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pix_q <= '0;
         else        pix_q <= mem[pix_addr];
      end
      assign pix_data = pix_q;
   end else begin : g_pix_comb
      assign pix_data = mem[pix_addr];
   end

endmodule

// File: rtl/pal_lut_port.sv
module pal_lut_port
   import pal_lut_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 6,
   parameter int unsigned DATA_W  = 8,
   parameter bit          PIX_REG = 1'b1,
   localparam int unsigned NCOMP  = PAL_NCOMP,
   localparam int unsigned RGB_W  = NCOMP * COMP_W,
   localparam int unsigned CW     = $clog2(NCOMP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [RGB_W-1:0]  pix_rgb
);

   if (COMP_W > DATA_W) begin : g_bad_comp
      $error("pal_lut_port: COMP_W must not exceed DATA_W");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("pal_lut_port: IDX_W must fit in the data register");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
      $error("pal_lut_port: IDX_W out of range 1..12");
   end

   pal_strobe_t strobe;

   logic [IDX_W-1:0]  wr_idx;
   logic [CW-1:0]     wr_comp;
   logic [IDX_W-1:0]  rd_idx;
   logic [CW-1:0]     rd_comp;
   logic [IDX_W-1:0]  mask_q;
   logic [IDX_W-1:0]  pix_addr;
   logic [COMP_W-1:0] bank_rd  [NCOMP];
   logic [COMP_W-1:0] bank_pix [NCOMP];
   logic [COMP_W-1:0] comp_sel;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   pal_reg_decode i_decode (
      .reg_en  (reg_en),
      .reg_we  (reg_we),
      .reg_sel (reg_sel),
      .strobe  (strobe)
   );

   pal_idx_seq #(.IDX_W(IDX_W), .NCOMP(NCOMP)) i_wseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (strobe.wptr_load),
      .load_val (reg_wdata[IDX_W-1:0]),
      .step     (strobe.data_wr),
      .idx      (wr_idx),
      .comp     (wr_comp)
   );

   pal_idx_seq #(.IDX_W(IDX_W), .NCOMP(NCOMP)) i_rseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (strobe.rptr_load),
      .load_val (reg_wdata[IDX_W-1:0]),
      .step     (strobe.data_rd),
      .idx      (rd_idx),
      .comp     (rd_comp)
   );

   // pixel mask register, transparent after reset
   always_ff @(posedge clk) begin
      if (!rst_n)              mask_q <= '1;
      else if (strobe.mask_wr) mask_q <= reg_wdata[IDX_W-1:0];
   end

   assign pix_addr = pix_idx & mask_q;

   // one storage bank per colour component, red first
   for (genvar c = 0; c < NCOMP; c++) begin : g_bank
      logic bank_we;
      assign bank_we = strobe.data_wr && (wr_comp == CW'(c));

      pal_comp_bank #(
         .IDX_W   (IDX_W),
         .COMP_W  (COMP_W),
         .PIX_REG (PIX_REG)
      ) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (bank_we),
         .waddr    (wr_idx),
         .wdata    (reg_wdata[COMP_W-1:0]),
         .raddr    (rd_idx),
         .rdata    (bank_rd[c]),
         .pix_addr (pix_addr),
         .pix_data (bank_pix[c])
      );

      assign pix_rgb[(NCOMP-1-c)*COMP_W +: COMP_W] = bank_pix[c];
   end

   // component chosen by the read counter
   always_comb begin
      comp_sel = '0;
      for (int c = 0; c < NCOMP; c++) begin
         if (rd_comp == CW'(c)) comp_sel = bank_rd[c];
      end
   end

   // register readback multiplexer
   always_comb begin
      unique case (pal_sel_e'(reg_sel))
         SEL_WPTR: rd_mux = DATA_W'(wr_idx);
         SEL_RPTR: rd_mux = DATA_W'(rd_idx);
         SEL_DATA: rd_mux = DATA_W'(comp_sel);
         SEL_MASK: rd_mux = DATA_W'(mask_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             rdata_q <= '0;
      else if (strobe.any_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;

endmodule

// File: rtl/pal_lut_port_chk.sv
module pal_lut_port_chk #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned COMP_W = 6,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_en,
   input logic              reg_we,
   input logic [1:0]        reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [CW-1:0]     wr_comp,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [CW-1:0]     rd_comp,
   input logic [IDX_W-1:0]  mask_q
);

   localparam logic [CW-1:0] LAST = CW'(2);

   logic wptr_wr, rptr_wr, data_wr, data_rd, mask_wr;
   assign wptr_wr = reg_en &&  reg_we && reg_sel == 2'd0;
   assign rptr_wr = reg_en &&  reg_we && reg_sel == 2'd1;
   assign data_wr = reg_en &&  reg_we && reg_sel == 2'd2;
   assign data_rd = reg_en && !reg_we && reg_sel == 2'd2;
   assign mask_wr = reg_en &&  reg_we && reg_sel == 2'd3;

   // R2
   wptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wptr_wr |=> (wr_idx == $past(reg_wdata[IDX_W-1:0])) && (wr_comp == '0));

   // R3
   data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && wr_comp != LAST) |=>
         (wr_idx == $past(wr_idx)) && ((wr_comp - $past(wr_comp)) == CW'(1)));

   // R4
   data_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && wr_comp == LAST) |=>
         (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (wr_comp == '0));

   // R5
   rptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_wr |=> (rd_idx == $past(reg_wdata[IDX_W-1:0])) && (rd_comp == '0));

   // R6
   rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |=> ((reg_rdata >> COMP_W) == '0));

   // R7
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(reg_wdata[IDX_W-1:0])));

   // R8
   wptr_keeps_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wptr_wr |=> $stable(rd_idx) && $stable(rd_comp));

   // R8
   rptr_keeps_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_wr |=> $stable(wr_idx) && $stable(wr_comp));

endmodule

bind pal_lut_port pal_lut_port_chk #(
   .IDX_W  (IDX_W),
   .COMP_W (COMP_W),
   .DATA_W (DATA_W),
   .CW     (CW)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_en    (reg_en),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .wr_idx    (wr_idx),
   .wr_comp   (wr_comp),
   .rd_idx    (rd_idx),
   .rd_comp   (rd_comp),
   .mask_q    (mask_q)
);

// File: tb/test_pal_lut_port.sv
`timescale 1ns/1ps
module test_pal_lut_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_en = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic [7:0]  pix_idx = 8'd0;
   logic [17:0] pix_rgb;

   int  checks = 0;
   int  errors = 0;
   bit  active = 1'b0;
   bit  done   = 1'b0;
   string phase = "R1 reset";

   always #5 clk = ~clk;

   pal_lut_port i_pal_lut_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_en    (reg_en),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pix_idx   (pix_idx),
      .pix_rgb   (pix_rgb)
   );

   // ---------------- behavioural reference ----------------
   logic [5:0]  tbl   [3][256];
   bit          known [3][256];
   int          wi, wc, ri, rc;
   logic [7:0]  mask;
   logic [7:0]  exp_rd;
   bit          rd_ok;
   string       rd_tag;
   logic [17:0] exp_pix;
   bit          pix_ok;
   string       pix_tag;

   initial begin
      for (int c = 0; c < 3; c++)
         for (int e = 0; e < 256; e++) begin
            tbl[c][e]   = 6'd0;
            known[c][e] = 1'b0;
         end
   end

   always @(posedge clk) begin
      logic [7:0] a;
      if (!rst_n) begin
         wi = 0; wc = 0; ri = 0; rc = 0; mask = 8'hFF;
         exp_rd = 8'h00; rd_ok = 1'b1; rd_tag = "R1";
         exp_pix = 18'd0; pix_ok = 1'b1; pix_tag = "R1";
      end else begin
         a       = pix_idx & mask;
         exp_pix = {tbl[0][a], tbl[1][a], tbl[2][a]};
         pix_ok  = known[0][a] && known[1][a] && known[2][a];
         pix_tag = (mask != 8'hFF) ? "R7" : "R9";
         if (reg_en && reg_we) begin
            case (reg_sel)
               2'd0: begin wi = reg_wdata; wc = 0; end
               2'd1: begin ri = reg_wdata; rc = 0; end
               2'd2: begin
                  if (wi == int'(a)) pix_tag = "R10";
                  tbl[wc][wi]   = reg_wdata[5:0];
                  known[wc][wi] = 1'b1;
                  if (wc == 2) begin wc = 0; wi = (wi + 1) % 256; end
                  else wc = wc + 1;
               end
               default: mask = reg_wdata;
            endcase
         end else if (reg_en) begin
            rd_ok = 1'b1;
            case (reg_sel)
               2'd0: begin exp_rd = 8'(wi); rd_tag = "R2"; end
               2'd1: begin exp_rd = 8'(ri); rd_tag = "R5"; end
               2'd2: begin
                  exp_rd = {2'b00, tbl[rc][ri]};
                  rd_ok  = known[rc][ri];
                  rd_tag = "R6";
                  if (rc == 2) begin rc = 0; ri = (ri + 1) % 256; end
                  else rc = rc + 1;
               end
               default: begin exp_rd = mask; rd_tag = "R7"; end
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (active && rst_n) begin
         if (rd_ok) begin
            checks++;
            if (reg_rdata !== exp_rd) begin
               errors++;
               $display("FAIL %s [%s] reg_rdata got %h exp %h", rd_tag, phase, reg_rdata, exp_rd);
            end
         end
         if (pix_ok) begin
            checks++;
            if (pix_rgb !== exp_pix) begin
               errors++;
               $display("FAIL %s [%s] pix_rgb got %h exp %h", pix_tag, phase, pix_rgb, exp_pix);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic acc(input bit we, input logic [1:0] sel, input logic [7:0] d);
      reg_en    = 1'b1;
      reg_we    = we;
      reg_sel   = sel;
      reg_wdata = d;
      @(negedge clk);
      reg_en    = 1'b0;
      reg_we    = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic direct(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s direct got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int e, input int c);
      return {2'b11, 6'((e * 7 + c * 13 + 5) & 63)};
   endfunction

   initial begin
      active = 1'b1;
      idle(4);
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      direct("R1", reg_rdata, 8'h00);
      acc(1'b0, 2'd3, 8'h00);          // R7 mask reads 0xFF after reset
      direct("R1", reg_rdata, 8'hFF);
      acc(1'b0, 2'd0, 8'h00);
      direct("R1", reg_rdata, 8'h00);

      phase = "R3 fill";
      acc(1'b1, 2'd0, 8'h00);
      for (int e = 0; e < 256; e++)
         for (int c = 0; c < 3; c++) begin
            pix_idx = 8'((e * 37) & 255);
            acc(1'b1, 2'd2, pat(e, c));
         end
      phase = "R4 wrap after full load";
      acc(1'b0, 2'd0, 8'h00);
      direct("R4", reg_rdata, 8'h00);

      phase = "R9 lookup sweep";
      for (int e = 0; e < 256; e++) begin pix_idx = 8'(e); idle(1); end
      pix_idx = 8'h5A; idle(2);
      direct("R9", 8'(pix_rgb[17:12]), 8'(pat(8'h5A, 0) & 8'h3F));

      phase = "R7 mask";
      acc(1'b1, 2'd3, 8'h0F);
      acc(1'b0, 2'd3, 8'h00);
      direct("R7", reg_rdata, 8'h0F);
      for (int e = 0; e < 256; e++) begin pix_idx = 8'((e * 11) & 255); idle(1); end
      acc(1'b1, 2'd3, 8'hFF);

      phase = "R5 readback";
      acc(1'b1, 2'd1, 8'd250);
      for (int k = 0; k < 24; k++) acc(1'b0, 2'd2, 8'h00);
      acc(1'b0, 2'd1, 8'h00);
      direct("R5", reg_rdata, 8'd2);

      phase = "R6 upper bits";
      acc(1'b1, 2'd1, 8'd9);
      acc(1'b0, 2'd2, 8'h00);
      direct("R6", reg_rdata, pat(9, 0) & 8'h3F);

      phase = "R8 independent counters";
      acc(1'b1, 2'd0, 8'd100);
      acc(1'b1, 2'd2, 8'hEA);
      acc(1'b1, 2'd1, 8'd100);
      acc(1'b0, 2'd2, 8'h00);
      direct("R8", reg_rdata, 8'h2A);
      acc(1'b1, 2'd2, 8'h15);
      acc(1'b0, 2'd2, 8'h00);
      direct("R8", reg_rdata, 8'h15);
      acc(1'b1, 2'd1, 8'd100);
      acc(1'b1, 2'd2, 8'h33);
      for (int k = 0; k < 3; k++) acc(1'b0, 2'd2, 8'h00);
      direct("R8", reg_rdata, 8'h33);
      acc(1'b0, 2'd0, 8'h00);
      direct("R8", reg_rdata, 8'd101);

      phase = "R2 reload mid entry";
      acc(1'b1, 2'd0, 8'd50);
      acc(1'b1, 2'd2, 8'h01);
      acc(1'b1, 2'd0, 8'd60);
      acc(1'b1, 2'd2, 8'h3E);
      acc(1'b0, 2'd0, 8'h00);
      direct("R2", reg_rdata, 8'd60);
      acc(1'b1, 2'd1, 8'd60);
      acc(1'b0, 2'd2, 8'h00);
      direct("R2", reg_rdata, 8'h3E);

      phase = "R4 wrap at top";
      acc(1'b1, 2'd0, 8'd255);
      for (int c = 0; c < 3; c++) acc(1'b1, 2'd2, 8'(8'h10 + c));
      acc(1'b0, 2'd0, 8'h00);
      direct("R4", reg_rdata, 8'h00);

      phase = "R10 collision";
      pix_idx = 8'd70;
      acc(1'b1, 2'd0, 8'd70);
      idle(1);
      acc(1'b1, 2'd2, 8'h3F);
      direct("R10", 8'(pix_rgb[17:12]), 8'(pat(70, 0) & 8'h3F));
      acc(1'b1, 2'd2, 8'h00);
      acc(1'b1, 2'd2, 8'h3F);
      idle(2);
      direct("R10", 8'(pix_rgb[17:12]), 8'h3F);

      idle(3);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule